// File: doc/BRIEF.md
# Shared-Memory Multi-Queue FIFO

This block keeps up to eight independent first-in first-out queues inside one storage array. The array is cut into equal blocks. At reset each queue is given a number of blocks through a configuration input, so queues can have different depths, and a queue given no blocks is simply unused. One write port and one read port serve all queues. Each port carries a queue address that selects the queue that port works on, and both ports can use the same queue or different queues in the same cycle.

The write port refuses data when the addressed queue is full. It shows full and almost-full flags for the queue on its address lines in the same cycle. The read port works as a fall-through port. When a queue is selected, its oldest word is loaded into the output register without a read enable. Each read enable then consumes the word on display. If the port moves to a queue that holds nothing, the output register keeps the last word it showed and the empty flag rises. Each queue has its own almost-full and almost-empty threshold. Thresholds and block counts are sampled while reset is held. Both ports share one clock.

Top module: `shq_fifo`

## Requirements
- R1: Queue i holds exactly cfg_blocks[i] × BLK_WORDS words. Block counts are packed BCW bits per queue, with queue 0 in the lowest bits. Queues are placed one after another in queue order.
- R2: A write is accepted only when the queue on wr_q is not full. wr_full shows, in the same cycle, whether the queue on wr_q currently holds its full capacity.
- R3: On the first clock edge at which a queue holding data is on rd_q, its oldest word is loaded into rd_data and rd_empty goes low. No read enable is needed for this.
- R4: rd_en while rd_empty is low consumes the word on rd_data. At that edge the next word of the queue now on rd_q is loaded. Each queue hands out its words in write order.
- R5: If, at an edge, the queue on rd_q has no word available, rd_empty goes high and rd_data keeps its previous value.
- R6: A word written into an empty queue reaches rd_data at the edge after the one that stored it, provided that queue is on rd_q.
- R7: A write and a read of the same queue in one cycle leave that queue's fill level unchanged.
- R8: wr_afull is high when the fill level of the queue on wr_q plus that queue's almost-full threshold is at least its capacity. Thresholds are packed CW bits per queue, with queue 0 lowest.
- R9: After each edge, rd_aempty is high when the number of words available to the queue on rd_q at that edge is at or below its almost-empty threshold. Words written at that same edge are not counted.
- R10: A queue with zero blocks shows wr_full high, drops every write, and reads as empty.
- R11: After reset, every queue is empty, rd_empty and rd_aempty are high, and rd_data is zero.
- R12: Traffic to one queue never changes the contents or order of any other queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset; configuration is sampled while it is high |
| cfg_blocks | input | NQ*BCW | Block count per queue |
| cfg_afull_thr | input | NQ*CW | Almost-full threshold per queue |
| cfg_aempty_thr | input | NQ*CW | Almost-empty threshold per queue |
| wr_en | input | 1 | Write request |
| wr_q | input | QW | Queue selected on the write port |
| wr_data | input | DW | Word to write |
| wr_full | output | 1 | Selected write queue is full |
| wr_afull | output | 1 | Selected write queue is almost full |
| rd_en | input | 1 | Consume the displayed word |
| rd_q | input | QW | Queue selected on the read port |
| rd_data | output | DW | Output register |
| rd_empty | output | 1 | Output register holds no valid word |
| rd_aempty | output | 1 | Queue shown on the read port is almost empty |

## Verification
The hardest case to reach is a cycle that combines several events: the read port consumes the displayed word of one queue, moves to another queue, and a write lands in a queue that is full or has just wrapped its pointer, all in the same cycle. Directed phases first fill small queues to full, wrap them, and switch the read port onto empty and zero-block queues. A long random phase then sets the read enable, write enable and both queue addresses independently on every cycle, over queues of one to four blocks. This makes same-queue, cross-queue and full-queue collisions common, and a behavioural model is compared against the outputs after every edge.

// File: rtl/shq_pkg.sv
package shq_pkg;

    localparam int unsigned SHQ_MAX_QUEUES = 8;

    // index width that never collapses to zero bits
    function automatic int unsigned shq_idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/shq_alloc.sv
module shq_alloc #(
    parameter int unsigned NQ        = 8,
    parameter int unsigned BLK_WORDS = 4,
    parameter int unsigned BCW       = 5,
    parameter int unsigned AW        = 6,
    parameter int unsigned CW        = 7
) (
    input  logic [NQ*BCW-1:0]       cfg_blocks,
    output logic [NQ-1:0][AW-1:0]   base,
    output logic [NQ-1:0][CW-1:0]   cap
);

    for (genvar i = 0; i < NQ; i++) begin : g_cap
        assign cap[i] = CW'(cfg_blocks[i*BCW +: BCW]) * CW'(BLK_WORDS);
    end

    always_comb begin
        logic [CW-1:0] acc;
        acc = '0;
        for (int i = 0; i < NQ; i++) begin
            base[i] = acc[AW-1:0];
            acc     = acc + cap[i];
        end
    end

endmodule

// File: rtl/shq_mem.sv
module shq_mem #(
    parameter int unsigned DW    = 36,
    parameter int unsigned DEPTH = 64,
    parameter int unsigned AW    = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/shq_level.sv
module shq_level #(
    parameter int unsigned CW = 7
) (
    input  logic [CW-1:0] fill,
    input  logic [CW-1:0] cap,
    input  logic [CW-1:0] thr,
    output logic          full,
    output logic          afull
);

    assign full  = (fill >= cap);
    assign afull = ({1'b0, fill} + {1'b0, thr}) >= {1'b0, cap};

endmodule

// File: rtl/shq_fifo.sv
module shq_fifo
    import shq_pkg::*;
#(
    parameter int unsigned NQ           = 8,
    parameter int unsigned DW           = 36,
    parameter int unsigned BLK_WORDS    = 4,
    parameter int unsigned TOTAL_BLOCKS = 16,
    localparam int unsigned DEPTH = TOTAL_BLOCKS * BLK_WORDS,
    localparam int unsigned AW    = shq_idx_w(DEPTH),
    localparam int unsigned CW    = $clog2(DEPTH + 1),
    localparam int unsigned BCW   = $clog2(TOTAL_BLOCKS + 1),
    localparam int unsigned QW    = shq_idx_w(NQ)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NQ*BCW-1:0] cfg_blocks,
    input  logic [NQ*CW-1:0]  cfg_afull_thr,
    input  logic [NQ*CW-1:0]  cfg_aempty_thr,
    input  logic              wr_en,
    input  logic [QW-1:0]     wr_q,
    input  logic [DW-1:0]     wr_data,
    output logic              wr_full,
    output logic              wr_afull,
    input  logic              rd_en,
    input  logic [QW-1:0]     rd_q,
    output logic [DW-1:0]     rd_data,
    output logic              rd_empty,
    output logic              rd_aempty
);

    typedef struct packed {
        logic [NQ-1:0][AW-1:0] rptr;
        logic [NQ-1:0][AW-1:0] wptr;
        logic [NQ-1:0][CW-1:0] fill;
        logic [NQ-1:0][AW-1:0] base;
        logic [NQ-1:0][CW-1:0] cap;
        logic [NQ-1:0][CW-1:0] af_thr;
        logic [NQ-1:0][CW-1:0] ae_thr;
        logic [DW-1:0]         dout;
        logic                  shown;
        logic                  low;
        logic [QW-1:0]         showq;
    } state_t;

    state_t state_q, state_d, state_rst;

    logic [NQ-1:0][AW-1:0] alloc_base;
    logic [NQ-1:0][CW-1:0] alloc_cap;
    logic                  push, pop, sel_full;
    logic [AW-1:0]         mem_raddr;
    logic [DW-1:0]         mem_rdata;

    function automatic logic [AW-1:0] ptr_next(
        input logic [AW-1:0] p,
        input logic [AW-1:0] b,
        input logic [CW-1:0] c
    );
        logic [CW-1:0] off;
        off = CW'(p - b) + CW'(1);
        if (off >= c) begin
            return b;
        end
        return p + AW'(1);
    endfunction

    shq_alloc #(
        .NQ(NQ), .BLK_WORDS(BLK_WORDS), .BCW(BCW), .AW(AW), .CW(CW)
    ) u_alloc (
        .cfg_blocks (cfg_blocks),
        .base       (alloc_base),
        .cap        (alloc_cap)
    );

    shq_level #(.CW(CW)) u_wlevel (
        .fill  (state_q.fill[wr_q]),
        .cap   (state_q.cap[wr_q]),
        .thr   (state_q.af_thr[wr_q]),
        .full  (sel_full),
        .afull (wr_afull)
    );

    assign push = wr_en & ~sel_full;
    assign pop  = rd_en & state_q.shown;

    // address of the word the read port will show after this edge
    always_comb begin
        mem_raddr = state_q.rptr[rd_q];
        if (pop && (state_q.showq == rd_q)) begin
            mem_raddr = ptr_next(state_q.rptr[rd_q], state_q.base[rd_q],
                                 state_q.cap[rd_q]);
        end
    end

    shq_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (push),
        .waddr (state_q.wptr[wr_q]),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    always_comb begin
        state_rst        = '0;
        state_rst.rptr   = alloc_base;
        state_rst.wptr   = alloc_base;
        state_rst.base   = alloc_base;
        state_rst.cap    = alloc_cap;
        state_rst.af_thr = cfg_afull_thr;
        state_rst.ae_thr = cfg_aempty_thr;
        state_rst.low    = 1'b1;
    end

    always_comb begin
        logic [CW-1:0] avail;
        state_d = state_q;

        if (pop) begin
            state_d.rptr[state_q.showq] = ptr_next(state_q.rptr[state_q.showq],
                                                   state_q.base[state_q.showq],
                                                   state_q.cap[state_q.showq]);
        end
        if (push) begin
            state_d.wptr[wr_q] = ptr_next(state_q.wptr[wr_q], state_q.base[wr_q],
                                          state_q.cap[wr_q]);
        end

        for (int i = 0; i < NQ; i++) begin
            state_d.fill[i] = state_q.fill[i]
                            + CW'(push && (wr_q == QW'(i)))
                            - CW'(pop && (state_q.showq == QW'(i)));
        end

        avail = state_q.fill[rd_q] - CW'(pop && (state_q.showq == rd_q));
        if (avail != '0) begin
            state_d.dout  = mem_rdata;
            state_d.shown = 1'b1;
        end else begin
            state_d.shown = 1'b0;
        end
        state_d.low   = (avail <= state_q.ae_thr[rd_q]);
        state_d.showq = rd_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= state_rst;
        end else begin
            state_q <= state_d;
        end
    end

    assign wr_full   = sel_full;
    assign rd_data   = state_q.dout;
    assign rd_empty  = ~state_q.shown;
    assign rd_aempty = state_q.low;

endmodule

// File: rtl/shq_fifo_chk.sv
module shq_fifo_chk #(
    parameter int unsigned DW = 36
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_full,
    input logic          wr_afull,
    input logic [DW-1:0] rd_data,
    input logic          rd_empty,
    input logic          rd_aempty
);

    // R5: an empty output register never changes its word
    a_r5_hold_when_empty: assert property (@(posedge clk) disable iff (rst)
        rd_empty |-> $stable(rd_data));

    // R8: a full queue is always reported as almost full too
    a_r8_full_is_afull: assert property (@(posedge clk) disable iff (rst)
        wr_full |-> wr_afull);

    // R9: nothing shown means nothing available, which is at or below any threshold
    a_r9_empty_is_aempty: assert property (@(posedge clk) disable iff (rst)
        rd_empty |-> rd_aempty);

    // R11: reset leaves the read port empty and almost empty
    a_r11_reset_empty: assert property (@(posedge clk)
        rst |=> (rd_empty && rd_aempty));

endmodule

bind shq_fifo shq_fifo_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_full   (wr_full),
    .wr_afull  (wr_afull),
    .rd_data   (rd_data),
    .rd_empty  (rd_empty),
    .rd_aempty (rd_aempty)
);

// File: tb/shq_fifo_bench.sv
module shq_fifo_bench;

    localparam int NQ = 8, DW = 36, BLK = 4, TB = 16;
    localparam int CW = 7, BCW = 5, QW = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NQ*BCW-1:0] cfg_blocks;
    logic [NQ*CW-1:0]  cfg_afull_thr, cfg_aempty_thr;
    logic              wr_en = 1'b0, rd_en = 1'b0;
    logic [QW-1:0]     wr_q = '0, rd_q = '0;
    logic [DW-1:0]     wr_data = '0;
    logic              wr_full, wr_afull, rd_empty, rd_aempty;
    logic [DW-1:0]     rd_data;

    always #2.5 clk = ~clk;

    shq_fifo #(.NQ(NQ), .DW(DW), .BLK_WORDS(BLK), .TOTAL_BLOCKS(TB)) u_shq_fifo (
        .clk(clk), .rst(rst), .cfg_blocks(cfg_blocks),
        .cfg_afull_thr(cfg_afull_thr), .cfg_aempty_thr(cfg_aempty_thr),
        .wr_en(wr_en), .wr_q(wr_q), .wr_data(wr_data),
        .wr_full(wr_full), .wr_afull(wr_afull),
        .rd_en(rd_en), .rd_q(rd_q), .rd_data(rd_data),
        .rd_empty(rd_empty), .rd_aempty(rd_aempty)
    );

    // configuration: q3 gets no blocks (R10); sum is 16 blocks
    int blocks [NQ] = '{2, 1, 3, 0, 4, 1, 2, 3};
    int af_thr [NQ] = '{2, 1, 3, 0, 5, 0, 4, 2};
    int ae_thr [NQ] = '{2, 0, 1, 0, 3, 1, 0, 4};

    // behavioural model
    logic [DW-1:0] mq [NQ][$];
    logic [DW-1:0] m_dout;
    logic          m_empty, m_ae;
    int            m_oq;
    int            n_chk = 0, n_err = 0;
    int            seq = 0;
    string         phase = "R11 reset";
    bit            done = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s [%s] actual=%h expected=%h", tag, phase, act, exp);
        end
    endtask

    function automatic int cap_of(input int q);
        return blocks[q] * BLK;
    endfunction

    task automatic step(input bit we, input int wq, input bit re, input int rq);
        logic [DW-1:0] wd;
        int av;
        bit pop_m, push_m;
        @(negedge clk);
        seq++;
        wd = {4'(wq), 32'(seq)};
        wr_en = we; wr_q = QW'(wq); wr_data = wd; rd_en = re; rd_q = QW'(rq);
        #1;
        chk("R2 wr_full", 64'(wr_full), 64'(mq[wq].size() >= cap_of(wq)));
        chk("R8 wr_afull", 64'(wr_afull), 64'(mq[wq].size() + af_thr[wq] >= cap_of(wq)));
        chk("R3 rd_empty", 64'(rd_empty), 64'(m_empty));
        chk("R9 rd_aempty", 64'(rd_aempty), 64'(m_ae));
        chk(m_empty ? "R5 rd_data held" : "R4 rd_data", 64'(rd_data), 64'(m_dout));
        @(posedge clk);
        pop_m  = re && !m_empty;
        push_m = we && (mq[wq].size() < cap_of(wq));
        av = mq[rq].size() - ((pop_m && m_oq == rq) ? 1 : 0);
        if (pop_m) void'(mq[m_oq].pop_front());
        if (av > 0) begin
            m_dout  = mq[rq][0];
            m_empty = 1'b0;
        end else begin
            m_empty = 1'b1;
        end
        m_ae = (av <= ae_thr[rq]);
        m_oq = rq;
        if (push_m) mq[wq].push_back(wd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NQ; i++) begin
            cfg_blocks[i*BCW +: BCW]    = BCW'(blocks[i]);
            cfg_afull_thr[i*CW +: CW]   = CW'(af_thr[i]);
            cfg_aempty_thr[i*CW +: CW]  = CW'(ae_thr[i]);
        end
        m_dout = '0; m_empty = 1'b1; m_ae = 1'b1; m_oq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11: state straight after reset
        #1;
        chk("R11 rd_empty", 64'(rd_empty), 64'd1);
        chk("R11 rd_aempty", 64'(rd_aempty), 64'd1);
        chk("R11 rd_data", 64'(rd_data), 64'd0);
        step(0, 0, 0, 0);
        step(0, 0, 1, 0);

        phase = "R1 R2 fill q1 past capacity";
        for (int i = 0; i < 6; i++) step(1, 1, 0, 3);
        phase = "R1 fill q0";
        for (int i = 0; i < 10; i++) step(1, 0, 0, 3);
        phase = "R10 zero-block queue";
        for (int i = 0; i < 3; i++) step(1, 3, 1, 3);

        phase = "R3 fall through on select";
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        phase = "R4 drain in order";
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0);

        phase = "R5 switch to empty queue";
        for (int i = 0; i < 3; i++) step(0, 0, 0, 5);

        phase = "R6 write into selected empty queue";
        step(1, 5, 0, 5);
        #1;
        chk("R6 not yet visible", 64'(rd_empty), 64'd1);
        step(0, 0, 0, 5);
        #1;
        chk("R6 visible one edge later", 64'(rd_empty), 64'd0);
        step(0, 0, 1, 5);
        step(0, 0, 0, 5);

        phase = "R7 same-queue write and read";
        for (int i = 0; i < 9; i++) step(1, 2, 0, 2);
        for (int i = 0; i < 20; i++) step(1, 2, 1, 2);
        #1;
        chk("R7 level kept at 9 of 12", 64'(mq[2].size()), 64'd9);

        phase = "R12 random mixed traffic";
        for (int i = 0; i < 4000; i++) begin
            step(bit'($urandom_range(0, 1)), $urandom_range(0, NQ-1),
                 bit'($urandom_range(0, 1)), $urandom_range(0, NQ-1));
        end

        phase = "R12 final drain";
        for (int q = 0; q < NQ; q++) begin
            for (int i = 0; i < 20; i++) step(0, 0, 1, q);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule